// File: doc/BRIEF.md
# Spiking Pattern Sequencer with Refractory Hand-off

This block is the synchronous controller of a two-unit spiking neuron. One unit integrates the synaptic input. The other unit is driven by a fixed bias and sets the refractory time. Each unit has a comparator that watches the current it senses and produces a spike-detect level. The controller turns those levels into clean one-cycle events. It decides which unit is wired to its voltage source and how strongly the integrating unit is driven for its next spike.

Drive strength comes from a small pattern register. The register's top bit selects full strength (short spike time) or reduced strength through a series resistance (longer spike time). It shifts left once per integration spike. In chattering mode the bit that leaves the top re-enters at the bottom, so the pattern repeats. In bursting mode zeros fill in from the bottom, so the neuron settles into slow spiking. A separate two-bit toggle flips on every accepted spike from either unit. The integration unit therefore rests, unconnected, for exactly one refractory spike time after each of its own spikes.

Top module: `spk_pattern_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the pattern register takes `pat_value`, the integration unit is connected (`int_conn_n`=0, `ref_conn_n`=1), and `strength_full` then equals `pat_value[3]`.
- R2: `strength_full` is the pattern register's most significant bit: 1 selects full drive, 0 selects reduced drive.
- R3: With `wrap_mode`=1 (chattering), an accepted integration spike rotates the 4-bit pattern left, and the old MSB moves into bit 0 (1110 -> 1101 -> 1011 -> 0111 -> 1110).
- R4: With `wrap_mode`=0 (bursting), an accepted integration spike shifts the pattern left, and a 0 enters bit 0 (1110 -> 1100 -> 1000 -> 0000).
- R5: Exactly one unit is connected at all times. The connection swaps on every accepted spike from either unit. Active-low enables: 0 means connected.
- R6: A refractory-unit spike never changes the pattern register.
- R7: A spike from the unit that is currently disconnected is ignored: neither the pattern nor the connection changes.
- R8: A spike-detect level takes effect once per rising edge, however long it stays high. The outputs change at the third rising clock edge after the level first rises (two synchronizer stages plus the state register).
- R9: If `pat_load` is high in the same cycle an integration spike is accepted, the pattern register takes `pat_value` instead of shifting. The connection still swaps.
- R10: With no spike accepted, `pat_load`=1 at a clock edge copies `pat_value` into the pattern register.
- R11: After the integration unit fires, it stays disconnected until the refractory unit fires. The refractory unit firing reconnects it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pat_load | input | 1 | Pattern load strobe |
| pat_value | input | 4 | Pattern to load, also the reset pattern |
| wrap_mode | input | 1 | 1 = chattering (rotate), 0 = bursting (zero fill) |
| spike_int | input | 1 | Spike-detect level from the integration unit (asynchronous) |
| spike_ref | input | 1 | Spike-detect level from the refractory unit (asynchronous) |
| strength_full | output | 1 | 1 = full drive, 0 = reduced drive for the integration unit |
| int_conn_n | output | 1 | Integration unit switch, 0 = connected |
| ref_conn_n | output | 1 | Refractory unit switch, 0 = connected |

## Verification
The assertions assume `pat_value` and `wrap_mode` are stable whenever they matter. They also assume each spike-detect level stays low for at least two clock cycles between pulses, so the synchronizer can see a falling level before the next rise. The stimulus holds every spike level high for five cycles and low for at least four. It changes the pattern inputs only at falling edges, outside any accepted event. The one exception is the load-priority case, which deliberately lines up `pat_load` with the event cycle.

// File: rtl/spk_pkg.sv
package spk_pkg;
  typedef enum logic {
    FILL_ZERO   = 1'b0,
    FILL_ROTATE = 1'b1
  } fill_mode_e;

  localparam int unsigned PAT_W_DEF  = 4;
  localparam int unsigned SYNC_N_DEF = 2;
  localparam int unsigned TOG_W_DEF  = 2;
endpackage

// File: rtl/spk_edge_sync.sv
module spk_edge_sync #(
  parameter int unsigned SYNC_N = spk_pkg::SYNC_N_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic rise_pulse
);
  localparam int unsigned LAST = SYNC_N - 1;

  logic [SYNC_N-1:0] stage_q;
  logic              hist_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_N; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[g] <= 1'b0;
          else        stage_q[g] <= level_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[g] <= 1'b0;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) hist_q <= 1'b0;
    else        hist_q <= stage_q[LAST];
  end

  assign rise_pulse = stage_q[LAST] & ~hist_q;

  // R8: one rising level gives a single-cycle pulse
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |=> !rise_pulse);
endmodule

// File: rtl/spk_pattern_reg.sv
module spk_pattern_reg #(
  parameter int unsigned PAT_W = spk_pkg::PAT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PAT_W-1:0] init_value,
  input  logic             load,
  input  logic             fill_rotate,
  input  logic             advance,
  output logic             msb
);
  import spk_pkg::*;

  localparam int unsigned TOP = PAT_W - 1;

  logic [PAT_W-1:0] pat_q;
  logic [PAT_W-1:0] pat_d;
  logic             fill_bit;
  fill_mode_e       mode;

  assign mode     = fill_rotate ? FILL_ROTATE : FILL_ZERO;
  assign fill_bit = (mode == FILL_ROTATE) ? pat_q[TOP] : 1'b0;

  always_comb begin
    pat_d = pat_q;
    if (load)         pat_d = init_value;
    else if (advance) pat_d = {pat_q[TOP-1:0], fill_bit};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pat_q <= init_value;
    else        pat_q <= pat_d;
  end

  assign msb = pat_q[TOP];

  p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> pat_q == $past(init_value));
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !advance) |=> $stable(pat_q));
  p_rotate_keeps_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load && fill_rotate) |=> $countones(pat_q) == $countones($past(pat_q)));
  p_zero_enters_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load && !fill_rotate) |=> !pat_q[0]);
endmodule

// File: rtl/spk_toggle.sv
module spk_toggle #(
  parameter int unsigned TOG_W = spk_pkg::TOG_W_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic int_off
);
  localparam int unsigned TOP = TOG_W - 1;
  localparam logic [TOG_W-1:0] TOG_RST = {{(TOG_W-1){1'b0}}, 1'b1};

  logic [TOG_W-1:0] tog_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    tog_q <= TOG_RST;
    else if (fire) tog_q <= {tog_q[TOP-1:0], tog_q[TOP]};
  end

  assign int_off = tog_q[TOP];

  p_tog_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tog_q) == 1);
  p_flip_on_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> int_off != $past(int_off));
  p_hold_no_fire_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(int_off));
endmodule

// File: rtl/spk_pattern_seq.sv
module spk_pattern_seq #(
  parameter int unsigned PAT_W  = spk_pkg::PAT_W_DEF,
  parameter int unsigned SYNC_N = spk_pkg::SYNC_N_DEF,
  parameter int unsigned TOG_W  = spk_pkg::TOG_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pat_load,
  input  logic [PAT_W-1:0] pat_value,
  input  logic             wrap_mode,
  input  logic             spike_int,
  input  logic             spike_ref,
  output logic             strength_full,
  output logic             int_conn_n,
  output logic             ref_conn_n
);
  localparam int unsigned N_UNITS = 2;

  logic [N_UNITS-1:0] raw_spk;
  logic [N_UNITS-1:0] rise;
  logic               int_off;
  logic               ev_int;
  logic               ev_ref;
  logic               ev_any;

  assign raw_spk = {spike_ref, spike_int};

  genvar u;
  generate
    for (u = 0; u < N_UNITS; u++) begin : g_unit
      spk_edge_sync #(.SYNC_N(SYNC_N)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_in  (raw_spk[u]),
        .rise_pulse(rise[u])
      );
    end
  endgenerate

  // only the connected unit may advance the state
  assign ev_int = rise[0] & ~int_off;
  assign ev_ref = rise[1] &  int_off;
  assign ev_any = ev_int | ev_ref;

  spk_pattern_reg #(.PAT_W(PAT_W)) pat_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_value (pat_value),
    .load       (pat_load),
    .fill_rotate(wrap_mode),
    .advance    (ev_int),
    .msb        (strength_full)
  );

  spk_toggle #(.TOG_W(TOG_W)) tog_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (ev_any),
    .int_off(int_off)
  );

  assign int_conn_n = int_off;
  assign ref_conn_n = ~int_off;

  p_one_connected_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~int_conn_n, ~ref_conn_n}) && (int_conn_n != ref_conn_n));
  p_ref_keeps_pattern_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ref && !pat_load) |=> $stable(strength_full));
  p_off_unit_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise[0] && int_conn_n && !rise[1]) |=> $stable(int_conn_n));
endmodule

// File: tb/spk_pattern_seq_tb_top.sv
module spk_pattern_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pat_load = 1'b0;
  logic [3:0] pat_value = 4'b0;
  logic       wrap_mode = 1'b0;
  logic       spike_int = 1'b0;
  logic       spike_ref = 1'b0;
  logic       strength_full;
  logic       int_conn_n;
  logic       ref_conn_n;

  int checks = 0;
  int failures = 0;
  logic [3:0] m_pat;
  logic       m_off;

  always #5 clk = ~clk;

  spk_pattern_seq dut_i (
    .clk(clk), .rst_n(rst_n), .pat_load(pat_load), .pat_value(pat_value),
    .wrap_mode(wrap_mode), .spike_int(spike_int), .spike_ref(spike_ref),
    .strength_full(strength_full), .int_conn_n(int_conn_n), .ref_conn_n(ref_conn_n)
  );

  function automatic logic [3:0] nxt(logic [3:0] p, logic w);
    return {p[2:0], w ? p[3] : 1'b0};
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_state(string tag);
    chk({tag, " strength"}, strength_full, m_pat[3]);
    chk({tag, " int_conn_n"}, int_conn_n, m_off);
    chk({tag, " ref_conn_n"}, ref_conn_n, !m_off);
  endtask

  task automatic do_reset(logic [3:0] v, logic w);
    @(negedge clk);
    rst_n = 1'b0; pat_value = v; wrap_mode = w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_pat = v; m_off = 1'b0;
  endtask

  task automatic fire(bit is_int);
    @(negedge clk);
    if (is_int) spike_int = 1'b1; else spike_ref = 1'b1;
    repeat (5) @(negedge clk);
    spike_int = 1'b0; spike_ref = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // sweep every pattern in both fill modes
    for (int w = 0; w < 2; w++) begin
      for (int v = 0; v < 16; v++) begin
        do_reset(v[3:0], w[0]);
        chk_state("R1 reset");
        for (int k = 0; k < 6; k++) begin
          fire(1);
          m_pat = nxt(m_pat, w[0]); m_off = 1'b1;
          chk_state(w[0] ? "R3 R2 rotate" : "R4 R2 zero fill");
          fire(1);
          chk_state("R7 R11 int spike while off");
          fire(0);
          m_off = 1'b0;
          chk_state("R6 R11 ref spike");
          fire(0);
          chk_state("R7 ref spike while off");
        end
      end
    end

    // explicit chattering / bursting sequences from 1110
    do_reset(4'b1110, 1'b1);
    for (int k = 0; k < 8; k++) begin
      fire(1); fire(0);
      chk("R3 chatter msb", strength_full, (k % 4) != 2);
    end
    do_reset(4'b1110, 1'b0);
    for (int k = 0; k < 6; k++) begin
      fire(1); fire(0);
      chk("R4 burst msb", strength_full, k < 2);
    end

    // latency: change on the third rising edge
    do_reset(4'b1010, 1'b1);
    @(negedge clk); spike_int = 1'b1;
    @(negedge clk); chk("R8 latency edge1", int_conn_n, 0);
    @(negedge clk); chk("R8 latency edge2", int_conn_n, 0);
    @(negedge clk); chk("R8 latency edge3", int_conn_n, 1);
    chk("R8 latency strength", strength_full, 0);
    repeat (40) @(negedge clk);
    chk("R8 long level once", strength_full, 0);
    spike_int = 1'b0;
    repeat (4) @(negedge clk);
    fire(0);
    chk("R8 after ref", strength_full, 0);

    // load with no spike
    do_reset(4'b0000, 1'b0);
    @(negedge clk); pat_value = 4'b1001; pat_load = 1'b1;
    @(negedge clk); pat_load = 1'b0;
    chk("R10 load idle", strength_full, 1);
    chk("R10 conn unchanged", int_conn_n, 0);
    fire(1);
    chk("R10 loaded pattern shifts", strength_full, 0);

    // load coinciding with an accepted integration spike
    do_reset(4'b1000, 1'b0);
    @(negedge clk); spike_int = 1'b1;
    @(negedge clk);
    @(negedge clk); pat_value = 4'b0110; pat_load = 1'b1;
    @(negedge clk); pat_load = 1'b0;
    chk("R9 load wins strength", strength_full, 0);
    chk("R9 conn swaps", int_conn_n, 1);
    spike_int = 1'b0;
    repeat (4) @(negedge clk);
    fire(0);
    fire(1);
    chk("R9 loaded value shifted", strength_full, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule